// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block turns the master audio clock into a serial bit clock and a left/right frame clock. Both come from two integer dividers that count in the master clock domain. The first divider sets how many master cycles make one bit. The second sets how many bits make one frame. Each output clock has its own polarity control. A payload code states the frame length that the downstream serializer expects, and the block refuses to start when the two lengths disagree.

Alongside the clocks, the block gives a serializer single-cycle strobes in the master clock domain:

- one at the start of every bit, where data changes;
- one at mid-bit, the rising edge in normal polarity;
- one at the first bit of every frame.

A small sequencer takes start, pause and stop commands. It orders the divider enable and the output hold so that no partial data reaches the line. An idle policy decides whether the bit clock keeps running during a pause. The sequencer states are:

- ST_IDLE: divider off, output held.
- ST_ARM: divider on, output still held, lasts one cycle.
- ST_RUN: divider on, output released.
- ST_STOPPING: output held, divider still on, lasts one cycle.
- ST_PAUSING: output held, divider still on, lasts one cycle.
- ST_PAUSE: output held. The divider is on only when the continuous policy is selected.

The transitions are:

- ST_IDLE→ST_ARM when start is accepted.
- ST_ARM→ST_RUN unconditionally.
- ST_RUN→ST_STOPPING on stop.
- ST_RUN→ST_PAUSING on pause.
- ST_STOPPING→ST_IDLE.
- ST_PAUSING→ST_PAUSE.
- ST_PAUSE→ST_IDLE on stop.
- ST_PAUSE→ST_ARM when start is accepted.

Top module: `asc_clkgen`

## Requirements
- R1: After reset, bclk and fclk are low, out_hold is 1, all three strobes are 0 and config_error is 0.
- R2: With cfg_bdiv_m1 = M−1, one bit lasts M master cycles. bit_lead_stb fires in the first cycle of each bit. bit_mid_stb fires in cycle floor(M/2) of the bit. The un-inverted bclk is low before that cycle and high from it on.
- R3: With cfg_fdiv_m1 = F−1, a frame lasts F bits, so frame_stb repeats every M·F master cycles. frame_stb coincides with the bit_lead_stb of bit 0. The un-inverted fclk is low for the first floor(F/2) bits and high for the rest.
- R4: cfg_payload codes 0, 2 and 3 mean 32, 48 and 64 bits per frame, and code 1 is reserved. A start is refused when any of these holds:
  - the code is reserved;
  - F differs from the coded payload;
  - cfg_bdiv_m1 is 0.

  A refused start sets config_error and leaves the dividers off. config_error stays set until a start is accepted.
- R5: cfg_bclk_inv and cfg_fclk_inv (1 = inverted) invert their clocks, including the idle level. The strobes are unaffected.
- R6: An accepted start turns the divider on at the next edge with out_hold still 1. out_hold drops one cycle later.
- R7: A stop from run keeps out_hold high for one cycle with the divider still running, then turns the divider off. bclk then rests at its idle level.
- R8: A pause with cfg_continuous = 1 holds the output while bclk keeps toggling.
- R9: A pause with cfg_continuous = 0 holds the output and stops the divider. bclk rests at its idle level and no strobes fire.
- R10: From pause, start resumes through ST_ARM with the same ordering as R6, and stop returns to ST_IDLE.
- R11: Both divider counters clear while the divider is off, so the first bit after any enable is a full M cycles.
- R12: Divider values, polarities and policy are captured only while the divider is off. Changes made while it runs take effect at the next enable.
- R13: Stop wins over pause, and pause wins over start. Commands are ignored in ST_ARM, ST_STOPPING and ST_PAUSING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Start/resume command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cfg_bdiv_m1 | input | BDIV_W | Master cycles per bit minus one |
| cfg_fdiv_m1 | input | FDIV_W | Bits per frame minus one |
| cfg_payload | input | 2 | Payload code: 0=32, 2=48, 3=64, 1 reserved |
| cfg_bclk_inv | input | 1 | Invert bit clock |
| cfg_fclk_inv | input | 1 | Invert frame clock |
| cfg_continuous | input | 1 | 1 = bit clock runs during pause |
| bclk | output | 1 | Serial bit clock |
| fclk | output | 1 | Frame (left/right) clock |
| bit_lead_stb | output | 1 | Strobe at the start of each bit |
| bit_mid_stb | output | 1 | Strobe at mid-bit |
| frame_stb | output | 1 | Strobe at the first bit of each frame |
| out_hold | output | 1 | Serializer must hold its output |
| config_error | output | 1 | Last start was refused |

## Verification
Commands and configuration are driven and outputs sampled on the falling clock edge.

The responses to a command pulse are due as follows:

- The ST_ARM response (out_hold still 1, bit_lead_stb and frame_stb high) is due at the first falling edge after the capturing rising edge.
- The release of out_hold is due one sample later.
- After a stop, the divider must be quiet from the second sample on.

Frame and bit lengths are measured by counting samples between successive strobes, starting in the ST_ARM cycle. The expected values M·F, F and M·(F−floor(F/2)) are computed from the applied fields. Activity checks count bclk toggles and strobes over a fixed window of samples after each transition.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_STOPPING,
        ST_PAUSING,
        ST_PAUSE
    } asc_state_e;

    localparam logic [1:0] PAY_32   = 2'd0;
    localparam logic [1:0] PAY_RSVD = 2'd1;
    localparam logic [1:0] PAY_48   = 2'd2;
    localparam logic [1:0] PAY_64   = 2'd3;

    // Bits per frame implied by a payload code; 0 marks the reserved code.
    function automatic logic [6:0] payload_bits(input logic [1:0] code);
        unique case (code)
            PAY_32:   payload_bits = 7'd32;
            PAY_48:   payload_bits = 7'd48;
            PAY_64:   payload_bits = 7'd64;
            default:  payload_bits = 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/asc_seq.sv
module asc_seq
    import asc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_pause,
    input  logic cmd_stop,
    input  logic cfg_ok,
    input  logic continuous,
    output logic div_on,
    output logic hold,
    output logic err
);

    asc_state_e state_q, state_d;
    logic       start_try;
    logic       err_q;

    // A start is considered only where it is meaningful and no stop competes.
    assign start_try = cmd_start && !cmd_stop && !cmd_pause &&
                       (state_q == ST_IDLE || state_q == ST_PAUSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_try && cfg_ok) state_d = ST_ARM;
            end
            ST_ARM: begin
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (cmd_stop)       state_d = ST_STOPPING;
                else if (cmd_pause) state_d = ST_PAUSING;
            end
            ST_STOPPING: begin
                state_d = ST_IDLE;
            end
            ST_PAUSING: begin
                state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (cmd_stop)                  state_d = ST_IDLE;
                else if (start_try && cfg_ok)  state_d = ST_ARM;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        div_on = 1'b0;
        hold   = 1'b1;
        unique case (state_q)
            ST_IDLE:     begin div_on = 1'b0;       hold = 1'b1; end
            ST_ARM:      begin div_on = 1'b1;       hold = 1'b1; end
            ST_RUN:      begin div_on = 1'b1;       hold = 1'b0; end
            ST_STOPPING: begin div_on = 1'b1;       hold = 1'b1; end
            ST_PAUSING:  begin div_on = 1'b1;       hold = 1'b1; end
            ST_PAUSE:    begin div_on = continuous; hold = 1'b1; end
            default:     begin div_on = 1'b0;       hold = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (start_try) begin
            err_q <= !cfg_ok;
        end
    end

    assign err = err_q;

    AST_ARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> (state_q == ST_RUN)); // R6

    AST_ERR_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !div_on); // R4

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cmd_stop) |=> (state_q == ST_STOPPING)); // R13

endmodule

// File: rtl/asc_bit_div.sv
module asc_bit_div #(
    parameter int unsigned BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [BDIV_W-1:0] m_m1,
    output logic              lead,
    output logic              mid,
    output logic              last,
    output logic              level
);

    localparam int unsigned RW = BDIV_W + 1;

    logic [BDIV_W-1:0] cnt_q;
    logic [RW-1:0]     ratio;
    logic [RW-1:0]     half;

    assign ratio = {1'b0, m_m1} + RW'(1);
    assign half  = ratio >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || cnt_q == m_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + BDIV_W'(1);
        end
    end

    assign lead  = active && (cnt_q == '0);
    assign mid   = active && ({1'b0, cnt_q} == half);
    assign last  = active && (cnt_q == m_m1);
    assign level = active && ({1'b0, cnt_q} >= half);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= m_m1)); // R2

    AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && m_m1 != '0) |-> !(lead && mid)); // R2

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/asc_frame_div.sv
module asc_frame_div #(
    parameter int unsigned FDIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              advance,
    input  logic [FDIV_W-1:0] f_m1,
    output logic              first,
    output logic              level
);

    localparam int unsigned RW = FDIV_W + 1;

    logic [FDIV_W-1:0] bit_q;
    logic [RW-1:0]     half;

    assign half = ({1'b0, f_m1} + RW'(1)) >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (!active) begin
            bit_q <= '0;
        end else if (advance) begin
            bit_q <= (bit_q == f_m1) ? '0 : bit_q + FDIV_W'(1);
        end
    end

    assign first = active && (bit_q == '0);
    assign level = active && ({1'b0, bit_q} >= half);

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_q <= f_m1)); // R3

endmodule

// File: rtl/asc_clkgen.sv
module asc_clkgen
    import asc_pkg::*;
#(
    parameter int unsigned BDIV_W = 6,
    parameter int unsigned FDIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_pause,
    input  logic              cmd_stop,
    input  logic [BDIV_W-1:0] cfg_bdiv_m1,
    input  logic [FDIV_W-1:0] cfg_fdiv_m1,
    input  logic [1:0]        cfg_payload,
    input  logic              cfg_bclk_inv,
    input  logic              cfg_fclk_inv,
    input  logic              cfg_continuous,
    output logic              bclk,
    output logic              fclk,
    output logic              bit_lead_stb,
    output logic              bit_mid_stb,
    output logic              frame_stb,
    output logic              out_hold,
    output logic              config_error
);

    localparam int unsigned FW1 = FDIV_W + 1;

    logic              div_on;
    logic              hold;
    logic              cfg_ok;
    logic [BDIV_W-1:0] sh_bdiv_q;
    logic [FDIV_W-1:0] sh_fdiv_q;
    logic [1:0]        sh_pay_q;
    logic              sh_binv_q, sh_finv_q, sh_cont_q;
    logic [BDIV_W-1:0] sel_bdiv;
    logic [FDIV_W-1:0] sel_fdiv;
    logic [1:0]        sel_pay;
    logic              lead, mid, last, blvl;
    logic              ffirst, flvl;

    // Shadow copy follows the inputs only while the divider is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_bdiv_q <= '0;
            sh_fdiv_q <= '0;
            sh_pay_q  <= PAY_32;
            sh_binv_q <= 1'b0;
            sh_finv_q <= 1'b0;
            sh_cont_q <= 1'b0;
        end else if (!div_on) begin
            sh_bdiv_q <= cfg_bdiv_m1;
            sh_fdiv_q <= cfg_fdiv_m1;
            sh_pay_q  <= cfg_payload;
            sh_binv_q <= cfg_bclk_inv;
            sh_finv_q <= cfg_fclk_inv;
            sh_cont_q <= cfg_continuous;
        end
    end

    // Validate the values that the next enable will use.
    assign sel_bdiv = div_on ? sh_bdiv_q : cfg_bdiv_m1;
    assign sel_fdiv = div_on ? sh_fdiv_q : cfg_fdiv_m1;
    assign sel_pay  = div_on ? sh_pay_q  : cfg_payload;

    assign cfg_ok = (sel_pay != PAY_RSVD) &&
                    (sel_bdiv != '0) &&
                    (({1'b0, sel_fdiv} + FW1'(1)) == FW1'(payload_bits(sel_pay)));

    asc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_pause  (cmd_pause),
        .cmd_stop   (cmd_stop),
        .cfg_ok     (cfg_ok),
        .continuous (sh_cont_q),
        .div_on     (div_on),
        .hold       (hold),
        .err        (config_error)
    );

    asc_bit_div #(.BDIV_W(BDIV_W)) u_bit_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (div_on),
        .m_m1   (sh_bdiv_q),
        .lead   (lead),
        .mid    (mid),
        .last   (last),
        .level  (blvl)
    );

    asc_frame_div #(.FDIV_W(FDIV_W)) u_frame_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (div_on),
        .advance (last),
        .f_m1    (sh_fdiv_q),
        .first   (ffirst),
        .level   (flvl)
    );

    assign bclk         = blvl ^ sh_binv_q;
    assign fclk         = flvl ^ sh_finv_q;
    assign bit_lead_stb = lead;
    assign bit_mid_stb  = mid;
    assign frame_stb    = lead && ffirst;
    assign out_hold     = hold;

    AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_hold) |-> $past(div_on)); // R6

    AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_on) |-> $past(out_hold)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && $past(div_on)) |-> ($stable(sh_bdiv_q) && $stable(sh_fdiv_q))); // R12

    AST_FRAME_ON_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> bit_lead_stb); // R3

endmodule

// File: tb/asc_clkgen_tb.sv
`timescale 1ns/1ps
module asc_clkgen_tb_top;

    typedef struct packed {
        logic [5:0]  m;
        logic [11:0] f;
        logic [1:0]  code;
        logic        ok;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        '{m: 6'd3, f: 12'd31, code: 2'd0, ok: 1'b1},
        '{m: 6'd3, f: 12'd63, code: 2'd1, ok: 1'b0},
        '{m: 6'd1, f: 12'd47, code: 2'd2, ok: 1'b1},
        '{m: 6'd3, f: 12'd31, code: 2'd3, ok: 1'b0},
        '{m: 6'd2, f: 12'd63, code: 2'd3, ok: 1'b1},
        '{m: 6'd0, f: 12'd31, code: 2'd0, ok: 1'b0},
        '{m: 6'd5, f: 12'd47, code: 2'd2, ok: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_pause = 1'b0, cmd_stop = 1'b0;
    logic [5:0]  cfg_bdiv_m1 = 6'd3;
    logic [11:0] cfg_fdiv_m1 = 12'd31;
    logic [1:0]  cfg_payload = 2'd0;
    logic        cfg_bclk_inv = 1'b0, cfg_fclk_inv = 1'b0, cfg_continuous = 1'b0;
    logic        bclk, fclk, bit_lead_stb, bit_mid_stb, frame_stb, out_hold, config_error;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    asc_clkgen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_pause(cmd_pause), .cmd_stop(cmd_stop),
        .cfg_bdiv_m1(cfg_bdiv_m1), .cfg_fdiv_m1(cfg_fdiv_m1), .cfg_payload(cfg_payload),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_fclk_inv(cfg_fclk_inv), .cfg_continuous(cfg_continuous),
        .bclk(bclk), .fclk(fclk), .bit_lead_stb(bit_lead_stb), .bit_mid_stb(bit_mid_stb),
        .frame_stb(frame_stb), .out_hold(out_hold), .config_error(config_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit s, input bit p, input bit t);
        @(negedge clk);
        cmd_start = s; cmd_pause = p; cmd_stop = t;
        @(negedge clk);
        cmd_start = 0; cmd_pause = 0; cmd_stop = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts bclk toggles and lead strobes over n samples.
    task automatic activity(input int n, output int tog, output int leads);
        logic prev;
        tog = 0; leads = 0; prev = bclk;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bclk != prev) tog++;
            prev = bclk;
            leads += int'(bit_lead_stb);
        end
    endtask

    // Measures one frame starting at the current frame_stb sample.
    task automatic frame_measure(output int len, output int mids, output int hi);
        len = 0; mids = 0; hi = 0;
        do begin
            mids += int'(bit_mid_stb);
            hi   += int'(fclk);
            @(negedge clk);
            len++;
        end while (!frame_stb && len < 5000);
    endtask

    task automatic lead_gap(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!bit_lead_stb && gap < 500);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int len, mids, hi, tog, leads, gap, mm, ff;
        idle(3);
        // R1 reset state
        chk(bclk == 0 && fclk == 0, "R1 clocks low", int'({bclk, fclk}), 0);
        chk(out_hold == 1 && config_error == 0, "R1 hold/err", int'({out_hold, config_error}), 2);
        chk({bit_lead_stb, bit_mid_stb, frame_stb} == 3'b0, "R1 strobes",
            int'({bit_lead_stb, bit_mid_stb, frame_stb}), 0);
        rst_n = 1'b1;
        idle(2);

        // Vector table: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            cfg_bdiv_m1 = VECS[v].m; cfg_fdiv_m1 = VECS[v].f; cfg_payload = VECS[v].code;
            idle(1);
            pulse(1, 0, 0);
            chk(config_error == !VECS[v].ok, "R4 config_error", int'(config_error), int'(!VECS[v].ok));
            if (VECS[v].ok) begin
                mm = int'(VECS[v].m) + 1; ff = int'(VECS[v].f) + 1;
                chk(frame_stb == 1, "R3 frame_stb at arm", int'(frame_stb), 1);
                frame_measure(len, mids, hi);
                chk(len == mm * ff, "R3 frame period", len, mm * ff);
                chk(mids == ff, "R2 mid strobes per frame", mids, ff);
                chk(hi == mm * (ff - ff / 2), "R3 fclk high cycles", hi, mm * (ff - ff / 2));
                pulse(0, 0, 1);
                idle(2);
            end else begin
                activity(10, tog, leads);
                chk(leads == 0 && out_hold == 1, "R4 dividers stay off", leads, 0);
            end
        end

        // R6 R11 start order, full first bit after a mid-bit stop
        cfg_bdiv_m1 = 6'd3; cfg_fdiv_m1 = 12'd31; cfg_payload = 2'd0;
        pulse(1, 0, 0);
        idle(6);
        pulse(0, 0, 1);
        idle(2);
        pulse(1, 0, 0);
        chk(out_hold == 1 && bit_lead_stb == 1, "R6 arm: held with divider on",
            int'({out_hold, bit_lead_stb}), 3);
        lead_gap(gap);
        chk(gap == 4, "R11 first bit full length", gap, 4);
        chk(out_hold == 0, "R6 hold released", int'(out_hold), 0);

        // R7 stop order
        pulse(0, 0, 1);
        chk(out_hold == 1, "R7 hold first", int'(out_hold), 1);
        idle(1);
        activity(12, tog, leads);
        chk(tog == 0 && leads == 0 && bclk == 0, "R7 divider off after stop", tog + leads, 0);

        // R5 polarity
        cfg_bclk_inv = 1; cfg_fclk_inv = 1;
        idle(2);
        chk(bclk == 1 && fclk == 1, "R5 inverted idle levels", int'({bclk, fclk}), 3);
        pulse(1, 0, 0);
        chk(bclk == 1 && fclk == 1 && bit_lead_stb == 1, "R5 strobe unaffected by inversion",
            int'({bclk, fclk, bit_lead_stb}), 7);
        pulse(0, 0, 1);
        idle(2);
        cfg_bclk_inv = 0; cfg_fclk_inv = 0;

        // R8 continuous pause, R10 resume
        cfg_continuous = 1;
        idle(1);
        pulse(1, 0, 0);
        idle(5);
        pulse(0, 1, 0);
        idle(2);
        activity(16, tog, leads);
        chk(tog > 0 && out_hold == 1, "R8 bclk runs while held", tog, 8);
        pulse(1, 0, 0);
        chk(out_hold == 1, "R10 resume via arm", int'(out_hold), 1);
        idle(1);
        chk(out_hold == 0, "R10 resume releases hold", int'(out_hold), 0);

        // R13 stop beats pause (continuous would keep running)
        pulse(0, 1, 1);
        idle(2);
        activity(16, tog, leads);
        chk(tog == 0 && leads == 0, "R13 stop wins over pause", tog, 0);

        // R9 gated pause, R10 stop from pause
        cfg_continuous = 0;
        idle(1);
        pulse(1, 0, 0);
        idle(5);
        pulse(0, 1, 0);
        idle(2);
        activity(16, tog, leads);
        chk(tog == 0 && leads == 0 && out_hold == 1, "R9 gated pause quiet", tog + leads, 0);
        pulse(0, 0, 1);
        pulse(1, 0, 0);
        chk(out_hold == 1 && bit_lead_stb == 1, "R10 restart after stop from pause",
            int'({out_hold, bit_lead_stb}), 3);

        // R12 config frozen while running
        cfg_bdiv_m1 = 6'd1;
        idle(1);
        while (!frame_stb) @(negedge clk);
        frame_measure(len, mids, hi);
        chk(len == 128, "R12 running period unchanged", len, 128);
        pulse(0, 0, 1);
        idle(2);
        pulse(1, 0, 0);
        frame_measure(len, mids, hi);
        chk(len == 64, "R12 new divider after re-enable", len, 64);
        pulse(0, 0, 1);
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule